// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block keeps recently used address-translation entries close to the pipeline. A 20-bit virtual page number splits into a set index in its low bits and a tag in its high bits. The index picks one of 16 sets, and the four ways of that set are compared in parallel. Each way stores a 32-bit translation entry. A kind bit records whether the entry came from the directory level or the leaf level of a two-level page table, so one array serves both steps of a walk.

A lookup presents a page number, the wanted kind and the 12-bit page offset. One clock later the block returns hit, the cached entry and, for a leaf hit, the physical address. A separate walker installs entries through the fill port. A task-switch flush drops every entry except those the operating system marked global in bit 8 of the entry. The walker owns page walking and permission checks; this block only stores entries and matches them.

Top module: `xlat_cache`

## Requirements
- R1: After reset every way is invalid, `rs_valid`, `rs_hit`, `rs_entry` and `rs_paddr` are zero, and any lookup misses until a fill is made.
- R2: Bits [3:0] of a page number select the set and bits [19:4] form the tag. Page numbers that share the low bits but differ in the tag occupy different ways of the same set, and each still hits on its own.
- R3: A lookup is presented with `lk_valid` high. On the next clock edge `rs_valid` goes high. `rs_hit` is 1 if a valid way in the selected set has an equal tag and kind, and `rs_entry` then carries that way's stored entry. On a miss `rs_hit` and `rs_entry` are 0. With `lk_valid` low, `rs_valid` is 0 one cycle later.
- R4: `lk_dir` = 0 asks for a leaf entry and matches only ways whose kind bit is 0. `lk_dir` = 1 asks for a directory entry and matches only ways whose kind bit is 1. A leaf entry and a directory entry for the same page number live side by side.
- R5: On a leaf hit, `rs_paddr` is bits [31:12] of the entry followed by the 12-bit `lk_off`. On a directory hit or a miss, `rs_paddr` is 0.
- R6: A cycle with `ts_flush` high invalidates, in that single cycle, every way whose stored entry has bit 8 clear. Ways with bit 8 set stay valid and keep hitting.
- R7: A fill whose tag and kind are already present in the set rewrites that way in place. No second copy is made, and later lookups return the new entry.
- R8: A fill that matches no way goes into the lowest-numbered invalid way of its set.
- R9: When a set is full and the fill matches no way, the victim is the way named by that set's rotating pointer. The pointer is 0 after reset and steps by one (modulo 4) after each such replacement.
- R10: Fill, flush and lookup may share a cycle. The lookup sees the contents from before the edge. The victim is chosen from the contents before the flush. The flush acts first, and the new entry is then written and valid whatever its bit 8 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | 20 | Virtual page number to look up |
| lk_dir | input | 1 | Kind wanted: 1 = directory entry, 0 = leaf entry |
| lk_off | input | 12 | Page offset joined to the frame on a leaf hit |
| fl_valid | input | 1 | Install an entry this cycle |
| fl_vpn | input | 20 | Virtual page number of the installed entry |
| fl_dir | input | 1 | Kind of the installed entry |
| fl_entry | input | 32 | Translation entry to store |
| ts_flush | input | 1 | Task-switch flush of non-global entries |
| rs_valid | output | 1 | Result present, one cycle after `lk_valid` |
| rs_hit | output | 1 | Lookup found a matching entry |
| rs_entry | output | 32 | Matching entry, zero on a miss |
| rs_paddr | output | 32 | Physical address on a leaf hit, zero otherwise |

## Verification
The cycle that needs care is one where a fill and a task-switch flush land on the same edge, sometimes with a lookup of a way that is about to be dropped. Directed steps drive all three at once on a set that holds both a global and a non-global entry. They then check that the same-cycle lookup still saw the old way, that the non-global way is gone, and that the new non-global entry survived its own flush. Random traffic on a small pool of page numbers makes fills and flushes coincide many more times, and each result is judged against a bench model that applies victim choice, then the flush, then the write, in that order.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int XL_VPN_W   = 20;
   localparam int XL_SET_W   = 4;
   localparam int XL_WAYS    = 4;
   localparam int XL_ENT_W   = 32;
   localparam int XL_OFF_W   = 12;
   localparam int XL_GLB_BIT = 8;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/xlat_store.sv
module xlat_store #(
   parameter int SETS    = 16,
   parameter int WAYS    = 4,
   parameter int TAG_W   = 16,
   parameter int ENT_W   = 32,
   parameter int GLB_BIT = 8,
   localparam int SET_W  = $clog2(SETS),
   localparam int WAY_W  = $clog2(WAYS)
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     flush,
   input  logic                                     wr_en,
   input  logic [SET_W-1:0]                         wr_set,
   input  logic [WAY_W-1:0]                         wr_way,
   input  logic                                     wr_kind,
   input  logic [TAG_W-1:0]                         wr_tag,
   input  logic [ENT_W-1:0]                         wr_ent,
   output logic [SETS-1:0][WAYS-1:0]                v_q,
   output logic [SETS-1:0][WAYS-1:0]                kind_q,
   output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]     tag_q,
   output logic [SETS-1:0][WAYS-1:0][ENT_W-1:0]     ent_q
);
   // valid bits: flush first, then the write wins for its own way
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               if (flush && !ent_q[s][w][GLB_BIT]) v_q[s][w] <= 1'b0;
            end
         end
         if (wr_en) v_q[wr_set][wr_way] <= 1'b1;
      end
   end

   // payload needs no reset: it is qualified by the valid bit
   always_ff @(posedge clk) begin
      if (wr_en) begin
         kind_q[wr_set][wr_way] <= wr_kind;
         tag_q[wr_set][wr_way]  <= wr_tag;
         ent_q[wr_set][wr_way]  <= wr_ent;
      end
   end
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 16
) (
   input  logic [WAYS-1:0]             way_valid,
   input  logic [WAYS-1:0]             way_kind,
   input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
   input  logic                        want_kind,
   input  logic [TAG_W-1:0]            want_tag,
   output logic [WAYS-1:0]             hit_vec
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hit_vec[w] = way_valid[w] && (way_kind[w] == want_kind)
                          && (way_tag[w] == want_tag);
   end
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
   parameter int WAYS    = 4,
   localparam int WAY_W  = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  req,
   output logic             any,
   output logic [WAY_W-1:0] idx
);
   assign any = |req;

   if (WAYS == 2) begin : g_two
      assign idx = req[0] ? 1'b0 : 1'b1;
   end else begin : g_wide
      always_comb begin
         idx = '0;
         for (int i = WAYS - 1; i >= 0; i--) begin
            if (req[i]) idx = WAY_W'(i);
         end
      end
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int WAYS    = 4,
   localparam int WAY_W  = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  set_valid,
   input  logic [WAYS-1:0]  same_vec,
   input  logic [WAY_W-1:0] rr_ptr,
   output logic [WAY_W-1:0] way,
   output logic             use_rr
);
   logic             same_any, free_any;
   logic [WAY_W-1:0] same_idx, free_idx;

   xlat_pick #(.WAYS(WAYS)) u_same (.req(same_vec),   .any(same_any), .idx(same_idx));
   xlat_pick #(.WAYS(WAYS)) u_free (.req(~set_valid), .any(free_any), .idx(free_idx));

   // in-place rewrite beats a free slot, which beats rotation
   always_comb begin
      use_rr = 1'b0;
      if (same_any)      way = same_idx;
      else if (free_any) way = free_idx;
      else begin
         way    = rr_ptr;
         use_rr = 1'b1;
      end
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
   parameter int VPN_W   = xlat_pkg::XL_VPN_W,
   parameter int SET_W   = xlat_pkg::XL_SET_W,
   parameter int WAYS    = xlat_pkg::XL_WAYS,
   parameter int ENT_W   = xlat_pkg::XL_ENT_W,
   parameter int OFF_W   = xlat_pkg::XL_OFF_W,
   parameter int GLB_BIT = xlat_pkg::XL_GLB_BIT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic             lk_dir,
   input  logic [OFF_W-1:0] lk_off,
   input  logic             fl_valid,
   input  logic [VPN_W-1:0] fl_vpn,
   input  logic             fl_dir,
   input  logic [ENT_W-1:0] fl_entry,
   input  logic             ts_flush,
   output logic             rs_valid,
   output logic             rs_hit,
   output logic [ENT_W-1:0] rs_entry,
   output logic [ENT_W-1:0] rs_paddr
);
   localparam int SETS  = 1 << SET_W;
   localparam int TAG_W = VPN_W - SET_W;
   localparam int WAY_W = $clog2(WAYS);

   if (!xlat_pkg::is_pow2(WAYS) || WAYS < 2) begin : g_bad_ways
      $error("xlat_cache: WAYS must be a power of two, at least 2");
   end
   if (SET_W < 1 || SET_W >= VPN_W) begin : g_bad_set
      $error("xlat_cache: SET_W must lie between 1 and VPN_W-1");
   end
   if (GLB_BIT >= ENT_W || OFF_W >= ENT_W) begin : g_bad_ent
      $error("xlat_cache: entry too narrow for global bit or offset");
   end

   logic [SETS-1:0][WAYS-1:0]             v_q, kind_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
   logic [SETS-1:0][WAYS-1:0][ENT_W-1:0]  ent_q;
   logic [SETS-1:0][WAY_W-1:0]            rr_q;

   logic [SET_W-1:0] lk_set, fl_set;
   logic [TAG_W-1:0] lk_tag, fl_tag;
   assign lk_set = lk_vpn[SET_W-1:0];
   assign lk_tag = lk_vpn[VPN_W-1:SET_W];
   assign fl_set = fl_vpn[SET_W-1:0];
   assign fl_tag = fl_vpn[VPN_W-1:SET_W];

   // ---------------- lookup path ----------------
   logic [WAYS-1:0]  lk_hits;
   logic             lk_any;
   logic [WAY_W-1:0] lk_way;
   logic [ENT_W-1:0] lk_ent;

   xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
      .way_valid (v_q[lk_set]),
      .way_kind  (kind_q[lk_set]),
      .way_tag   (tag_q[lk_set]),
      .want_kind (lk_dir),
      .want_tag  (lk_tag),
      .hit_vec   (lk_hits)
   );
   xlat_pick #(.WAYS(WAYS)) u_lk_pick (.req(lk_hits), .any(lk_any), .idx(lk_way));
   assign lk_ent = ent_q[lk_set][lk_way];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_entry <= '0;
         rs_paddr <= '0;
      end else begin
         rs_valid <= lk_valid;
         rs_hit   <= lk_valid && lk_any;
         rs_entry <= (lk_valid && lk_any) ? lk_ent : '0;
         rs_paddr <= (lk_valid && lk_any && !lk_dir)
                     ? {lk_ent[ENT_W-1:OFF_W], lk_off} : '0;
      end
   end

   // ---------------- fill path ----------------
   logic [WAYS-1:0]  fl_same;
   logic [WAY_W-1:0] fl_way;
   logic             fl_rot;

   xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
      .way_valid (v_q[fl_set]),
      .way_kind  (kind_q[fl_set]),
      .way_tag   (tag_q[fl_set]),
      .want_kind (fl_dir),
      .want_tag  (fl_tag),
      .hit_vec   (fl_same)
   );
   xlat_victim #(.WAYS(WAYS)) u_victim (
      .set_valid (v_q[fl_set]),
      .same_vec  (fl_same),
      .rr_ptr    (rr_q[fl_set]),
      .way       (fl_way),
      .use_rr    (fl_rot)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rr_q <= '0;
      else if (fl_valid && fl_rot) rr_q[fl_set] <= rr_q[fl_set] + WAY_W'(1);
   end

   xlat_store #(
      .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .ENT_W(ENT_W), .GLB_BIT(GLB_BIT)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (ts_flush),
      .wr_en   (fl_valid),
      .wr_set  (fl_set),
      .wr_way  (fl_way),
      .wr_kind (fl_dir),
      .wr_tag  (fl_tag),
      .wr_ent  (fl_entry),
      .v_q     (v_q),
      .kind_q  (kind_q),
      .tag_q   (tag_q),
      .ent_q   (ent_q)
   );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int SETS    = 16,
   parameter int WAYS    = 4,
   parameter int TAG_W   = 16,
   parameter int ENT_W   = 32,
   parameter int OFF_W   = 12,
   parameter int GLB_BIT = 8
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  lk_valid,
   input logic                                  lk_dir,
   input logic [OFF_W-1:0]                      lk_off,
   input logic                                  fl_valid,
   input logic                                  ts_flush,
   input logic                                  rs_valid,
   input logic                                  rs_hit,
   input logic [ENT_W-1:0]                      rs_entry,
   input logic [ENT_W-1:0]                      rs_paddr,
   input logic [SETS-1:0][WAYS-1:0]             v_q,
   input logic [SETS-1:0][WAYS-1:0]             kind_q,
   input logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q,
   input logic [SETS-1:0][WAYS-1:0][ENT_W-1:0]  ent_q
);
   int  live_cnt, glb_cnt;
   logic dup_seen;

   always_comb begin
      live_cnt = 0;
      glb_cnt  = 0;
      dup_seen = 1'b0;
      for (int s = 0; s < SETS; s++) begin
         for (int a = 0; a < WAYS; a++) begin
            if (v_q[s][a]) live_cnt++;
            if (v_q[s][a] && ent_q[s][a][GLB_BIT]) glb_cnt++;
            for (int b = a + 1; b < WAYS; b++) begin
               if (v_q[s][a] && v_q[s][b] && kind_q[s][a] == kind_q[s][b]
                   && tag_q[s][a] == tag_q[s][b]) dup_seen = 1'b1;
            end
         end
      end
   end

   p_rs_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid);
   p_rs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rs_valid && !rs_hit);
   p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_hit |-> (rs_entry == '0) && (rs_paddr == '0));
   p_off_join_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_dir) |=> (!rs_hit || rs_paddr[OFF_W-1:0] == $past(lk_off)));
   p_dir_nopa_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_dir) |=> (rs_paddr == '0));
   p_flush_spare_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_flush && !fl_valid) |=> (live_cnt == $past(glb_cnt)));
   p_no_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !dup_seen);
endmodule

bind xlat_cache xlat_cache_chk #(
   .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .ENT_W(ENT_W),
   .OFF_W(OFF_W), .GLB_BIT(GLB_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_dir(lk_dir), .lk_off(lk_off),
   .fl_valid(fl_valid), .ts_flush(ts_flush), .rs_valid(rs_valid), .rs_hit(rs_hit),
   .rs_entry(rs_entry), .rs_paddr(rs_paddr), .v_q(v_q), .kind_q(kind_q),
   .tag_q(tag_q), .ent_q(ent_q)
);

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0, lk_dir = 1'b0, fl_valid = 1'b0, fl_dir = 1'b0, ts_flush = 1'b0;
   logic [19:0] lk_vpn = '0, fl_vpn = '0;
   logic [11:0] lk_off = '0;
   logic [31:0] fl_entry = '0;
   logic        rs_valid, rs_hit;
   logic [31:0] rs_entry, rs_paddr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   xlat_cache dut_i (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_dir(lk_dir),
      .lk_off(lk_off), .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_dir(fl_dir),
      .fl_entry(fl_entry), .ts_flush(ts_flush), .rs_valid(rs_valid), .rs_hit(rs_hit),
      .rs_entry(rs_entry), .rs_paddr(rs_paddr)
   );

   // ---------------- reference model ----------------
   bit        mv [16][4];
   bit        mk [16][4];
   bit [15:0] mt [16][4];
   bit [31:0] me [16][4];
   int        mrr[16];
   bit        e_valid, e_hit;
   bit [31:0] e_entry, e_paddr;

   task automatic model_reset();
      for (int s = 0; s < 16; s++) begin
         mrr[s] = 0;
         for (int w = 0; w < 4; w++) mv[s][w] = 0;
      end
      e_valid = 0; e_hit = 0; e_entry = 0; e_paddr = 0;
   endtask

   task automatic model_step();
      int s, vic;
      bit found;
      // lookup against pre-edge contents
      s = int'(lk_vpn[3:0]);
      e_valid = lk_valid; e_hit = 0; e_entry = 0; e_paddr = 0;
      if (lk_valid) begin
         for (int w = 0; w < 4; w++) begin
            if (!e_hit && mv[s][w] && mk[s][w] == lk_dir && mt[s][w] == lk_vpn[19:4]) begin
               e_hit = 1; e_entry = me[s][w];
               if (!lk_dir) e_paddr = {me[s][w][31:12], lk_off};
            end
         end
      end
      // victim from pre-flush state
      s = int'(fl_vpn[3:0]);
      vic = 0; found = 0;
      if (fl_valid) begin
         for (int w = 0; w < 4; w++)
            if (!found && mv[s][w] && mk[s][w] == fl_dir && mt[s][w] == fl_vpn[19:4]) begin
               vic = w; found = 1;
            end
         for (int w = 0; w < 4; w++)
            if (!found && !mv[s][w]) begin vic = w; found = 1; end
         if (!found) begin vic = mrr[s]; mrr[s] = (mrr[s] + 1) % 4; end
      end
      if (ts_flush)
         for (int a = 0; a < 16; a++)
            for (int w = 0; w < 4; w++)
               if (!me[a][w][8]) mv[a][w] = 0;
      if (fl_valid) begin
         mv[s][vic] = 1; mk[s][vic] = fl_dir; mt[s][vic] = fl_vpn[19:4]; me[s][vic] = fl_entry;
      end
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one clock: model, edge, compare at the falling edge
   task automatic run(input string req);
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk(req, "rs_valid", {31'b0, rs_valid}, {31'b0, e_valid});
      chk(req, "rs_hit",   {31'b0, rs_hit},   {31'b0, e_hit});
      chk(req, "rs_entry", rs_entry, e_entry);
      chk(req, "rs_paddr", rs_paddr, e_paddr);
      lk_valid = 0; fl_valid = 0; ts_flush = 0;
   endtask

   task automatic look(input logic [19:0] v, input bit d, input logic [11:0] o, input string req);
      lk_valid = 1; lk_vpn = v; lk_dir = d; lk_off = o;
      run(req);
   endtask

   task automatic fill(input logic [19:0] v, input bit d, input logic [31:0] e, input string req);
      fl_valid = 1; fl_vpn = v; fl_dir = d; fl_entry = e;
      run(req);
   endtask

   task automatic flush(input string req);
      ts_flush = 1;
      run(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0A17));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1: reset state and a miss on an empty array
      chk("R1", "rs_valid after reset", {31'b0, rs_valid}, 32'd0);
      chk("R1", "rs_entry after reset", rs_entry, 32'd0);
      look(20'h12345, 0, 12'h111, "R1");
      chk("R1", "empty miss", {31'b0, rs_hit}, 32'd0);

      // R3 R5: leaf hit builds the physical address
      fill(20'h12345, 0, 32'hABCDE003, "R3");
      look(20'h12345, 0, 12'h678, "R3");
      chk("R3", "leaf entry", rs_entry, 32'hABCDE003);
      chk("R5", "leaf paddr", rs_paddr, 32'hABCDE678);

      // R4: kinds are separate
      look(20'h12345, 1, 12'h0, "R4");
      chk("R4", "dir miss on leaf-only", {31'b0, rs_hit}, 32'd0);
      fill(20'h12345, 1, 32'h11111001, "R4");
      look(20'h12345, 1, 12'hFFF, "R4");
      chk("R4", "dir hit", rs_entry, 32'h11111001);
      chk("R5", "dir paddr zero", rs_paddr, 32'd0);

      // R2: other set misses, same set different tag coexists
      look(20'h12344, 0, 12'h0, "R2");
      chk("R2", "other set miss", {31'b0, rs_hit}, 32'd0);

      // R7: in-place rewrite, then fill set 5 to exactly four ways
      fill(20'h12345, 0, 32'h55555003, "R7");
      look(20'h12345, 0, 12'h001, "R7");
      chk("R7", "rewritten entry", rs_entry, 32'h55555003);
      fill(20'h22225, 0, 32'h22222003, "R2");
      fill(20'h33335, 0, 32'h33333003, "R2");
      look(20'h12345, 1, 12'h0, "R7");
      chk("R7", "dir still held", {31'b0, rs_hit}, 32'd1);
      look(20'h22225, 0, 12'h0, "R2");
      chk("R2", "same-set tag B", rs_entry, 32'h22222003);
      look(20'h33335, 0, 12'h0, "R2");
      chk("R2", "same-set tag C", rs_entry, 32'h33333003);

      // R9: full set rotates from way 0
      fill(20'h44445, 0, 32'h44444003, "R9");
      look(20'h12345, 0, 12'h0, "R9");
      chk("R9", "way0 evicted", {31'b0, rs_hit}, 32'd0);
      look(20'h12345, 1, 12'h0, "R9");
      chk("R9", "way1 kept", {31'b0, rs_hit}, 32'd1);
      fill(20'h66665, 0, 32'h66666003, "R9");
      look(20'h12345, 1, 12'h0, "R9");
      chk("R9", "way1 evicted next", {31'b0, rs_hit}, 32'd0);

      // R6 R8: set 9, global / non-global / global, flush, refill
      fill(20'hA0009, 0, 32'hA0000103, "R8");
      fill(20'hB0009, 0, 32'hB0000003, "R8");
      fill(20'hC0009, 0, 32'hC0000103, "R8");
      flush("R6");
      look(20'hB0009, 0, 12'h0, "R6");
      chk("R6", "non-global dropped", {31'b0, rs_hit}, 32'd0);
      look(20'hA0009, 0, 12'h0, "R6");
      chk("R6", "global kept", rs_entry, 32'hA0000103);
      fill(20'hD0009, 0, 32'hD0000003, "R8");
      fill(20'hE0009, 0, 32'hE0000003, "R8");
      fill(20'hF0009, 0, 32'hF0000003, "R9");
      look(20'hA0009, 0, 12'h0, "R9");
      chk("R9", "rotation hits way0", {31'b0, rs_hit}, 32'd0);
      look(20'hD0009, 0, 12'h0, "R8");
      chk("R8", "free way1 reused", rs_entry, 32'hD0000003);

      // R10: fill + flush + lookup in the same cycle, set 11
      fill(20'h1000B, 0, 32'h10000103, "R10");
      fill(20'h2000B, 0, 32'h20000003, "R10");
      lk_valid = 1; lk_vpn = 20'h2000B; lk_dir = 0; lk_off = 12'h0AB;
      fl_valid = 1; fl_vpn = 20'h3000B; fl_dir = 0; fl_entry = 32'h30000003;
      ts_flush = 1;
      run("R10");
      chk("R10", "lookup sees old way", rs_paddr, 32'h200000AB);
      look(20'h2000B, 0, 12'h0, "R10");
      chk("R10", "flushed way gone", {31'b0, rs_hit}, 32'd0);
      look(20'h3000B, 0, 12'h0, "R10");
      chk("R10", "new entry survives", rs_entry, 32'h30000003);
      look(20'h1000B, 0, 12'h0, "R10");
      chk("R10", "global survives", {31'b0, rs_hit}, 32'd1);

      // random traffic on a small pool of pages (R3 R6 R7 R9 R10)
      for (int i = 0; i < 4000; i++) begin
         lk_valid = ($urandom % 4) != 0;
         lk_vpn   = {12'h0, 4'($urandom % 5), 4'($urandom % 3)};
         lk_dir   = ($urandom % 3) == 0;
         lk_off   = 12'($urandom);
         fl_valid = ($urandom % 3) == 0;
         fl_vpn   = {12'h0, 4'($urandom % 5), 4'($urandom % 3)};
         fl_dir   = ($urandom % 3) == 0;
         fl_entry = $urandom;
         ts_flush = ($urandom % 23) == 0;
         run("R3");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule